// File: doc/BRIEF.md
# Resettable-Pointer Line Delay FIFO

A single-clock ring buffer of 5120 byte entries used to delay a stream of pixels by one scan line, or by any shorter programmable amount. A write pointer and a read pointer run around the same ring. Each pointer has its own active-low restart input and its own active-low advance enable. There are no full or empty flags. The caller sets the delay entirely through the spacing of the pointers. It can restart both pointers together, restart them a chosen number of cycles apart, or stall one of them for a while.

Incoming bytes are gathered four at a time into a 32-bit storage word. The word is committed when its highest byte lane is written. Reads select a byte from a committed word into a registered output. The output also has an active-low drive enable, modelled as a drive flag with the data forced to zero. This enable is independent of the read pointer, which keeps advancing while the output is not driven.

Because of the packing, a read that trails the write pointer very closely can return the byte stored in the previous pass around the ring.

Top module: `line_delay_fifo`

## Requirements
- R1: While `arst_n` is low, `rd_drive` and `rd_data` are 0 and both pointers are forced to address 0. After release, the first write goes to address 0 and the first read returns address 0.
- R2: At a rising edge with `wr_en_n` low, `wr_data` is stored at the write address and the write pointer advances by one, from 5119 back to 0. With `wr_en_n` high, nothing is stored and the pointer holds.
- R3: At a rising edge with `rd_en_n` low, the byte at the read address is loaded into the output register and the read pointer advances, from 5119 back to 0. With `rd_en_n` high, both the output byte and the pointer hold, so each stalled cycle adds one entry of delay.
- R4: `wr_rst_n` low at an edge makes that edge's write (if enabled) land at address 0, with the pointer then at 1. Without a write, the pointer goes to 0 and the next enabled write lands at address 0.
- R5: `rd_rst_n` low at an edge makes that edge's read (if enabled) fetch address 0. Without a read, the pointer goes to 0, the output byte is unchanged, and the next enabled read fetches address 0.
- R6: After each edge, `rd_drive` equals the inverse of `out_en_n` sampled at that edge. While `rd_drive` is 0, `rd_data` is 0. The read pointer advances with `rd_en_n` low whatever `out_en_n` is.
- R7: Restarting both pointers at the same edge with both enables active gives a delay of 5120: each output byte is the one written 5120 write cycles earlier.
- R8: With continuous enables, restarting the read pointer at an edge where the write pointer is at n (20 <= n <= 5119) gives a delay of n. Each output byte is the one written n write cycles earlier.
- R9: Addresses 4k to 4k+3 form one storage word, committed at the edge that writes address 4k+3. Suppose a read hits an address in the word being filled that lies below the current write position. The read returns that address's byte from before its latest rewrite, that is, from the previous line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| arst_n | input | 1 | Asynchronous system reset, active low |
| wr_rst_n | input | 1 | Write pointer restart to address 0, active low |
| wr_en_n | input | 1 | Write enable and write pointer advance, active low |
| wr_data | input | 8 | Byte to store |
| rd_rst_n | input | 1 | Read pointer restart to address 0, active low |
| rd_en_n | input | 1 | Read enable and read pointer advance, active low |
| out_en_n | input | 1 | Output drive enable, active low, registered |
| rd_data | output | 8 | Registered read byte, 0 while not driven |
| rd_drive | output | 1 | 1 when the output is driven, 0 for high impedance |

## Verification
The bench sweeps the read lag through 0, 1, 2, 3, 20, 21 and 333 entries. A design that commits words too early would return new-line bytes at lags 1 to 3. A design that commits too late, or selects the wrong lane, would return stale or shuffled bytes at lags of 20 and above. The bench also checks a read restart with the read disabled, a write restart with and without a write, stalls on either side, and output-disable cycles. A design that froze the read pointer during output disable would fail the checks on the bytes that follow. A design that placed the restart write at address 1, or let the read restart change the held output byte, would also be caught. A mid-run system reset at a word boundary confirms that both pointers return to address 0.

// File: rtl/lfifo_pkg.sv
package lfifo_pkg;

   typedef enum logic [1:0] {
      PTR_HOLD = 2'd0,
      PTR_STEP = 2'd1,
      PTR_ZERO = 2'd2
   } ptr_op_e;

   // An enabled cycle always steps from the effective address; a restart
   // without an enabled cycle only parks the pointer at zero.
   function automatic ptr_op_e ptr_decide(input logic en_n, input logic zero_n);
      if (!en_n)
         return PTR_STEP;
      else if (!zero_n)
         return PTR_ZERO;
      return PTR_HOLD;
   endfunction

endpackage

// File: rtl/lfifo_ring_ptr.sv
module lfifo_ring_ptr
   import lfifo_pkg::*;
#(
   parameter int unsigned DEPTH = 5120,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          en_n,
   input  logic          zero_n,
   output logic [AW-1:0] ptr_q,
   output logic [AW-1:0] cur_addr,
   output logic          step
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   ptr_op_e       op;
   logic [AW-1:0] nxt;

   always_comb begin
      cur_addr = zero_n ? ptr_q : '0;
      op       = ptr_decide(en_n, zero_n);
      step     = (op == PTR_STEP);
      unique case (op)
         PTR_STEP: nxt = (cur_addr == LAST) ? '0 : cur_addr + AW'(1);
         PTR_ZERO: nxt = '0;
         default:  nxt = ptr_q;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         ptr_q <= '0;
      else
         ptr_q <= nxt;
   end

   // R2
   ptr_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
      ptr_q <= LAST);

   // R2
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!en_n && cur_addr == LAST) |=> (ptr_q == '0));

   // R3
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (en_n && zero_n) |=> $stable(ptr_q));

endmodule

// File: rtl/lfifo_packer.sv
module lfifo_packer #(
   parameter int unsigned DW   = 8,
   parameter int unsigned PACK = 4,
   parameter int unsigned AW   = 13,
   parameter int unsigned LW   = (PACK > 1) ? $clog2(PACK) : 0,
   parameter int unsigned WAW  = AW - LW
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic               wr_go,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      din,
   output logic               commit,
   output logic [WAW-1:0]     commit_idx,
   output logic [PACK*DW-1:0] commit_word
);

   generate
      if (PACK == 1) begin : g_direct
         assign commit      = wr_go;
         assign commit_idx  = wr_addr;
         assign commit_word = din;
      end else begin : g_gather
         logic [LW-1:0]              lane;
         logic [PACK-1:0][DW-1:0]    stage_q;

         assign lane       = wr_addr[LW-1:0];
         assign commit_idx = wr_addr[AW-1:LW];
         assign commit     = wr_go && (lane == LW'(PACK - 1));

         for (genvar i = 0; i < PACK; i++) begin : g_lane
            assign commit_word[i*DW +: DW] = (lane == LW'(i)) ? din : stage_q[i];
         end

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)
               stage_q <= '0;
            else if (wr_go)
               stage_q[lane] <= din;
         end

         // R9
         stage_keep_chk: assert property (@(posedge clk) disable iff (!arst_n)
            !wr_go |=> $stable(stage_q));
      end
   endgenerate

endmodule

// File: rtl/lfifo_word_store.sv
module lfifo_word_store #(
   parameter int unsigned WW    = 32,
   parameter int unsigned WORDS = 1280,
   parameter int unsigned WAW   = 11
) (
   input  logic           clk,
   input  logic           we,
   input  logic [WAW-1:0] widx,
   input  logic [WW-1:0]  wword,
   input  logic [WAW-1:0] ridx,
   output logic [WW-1:0]  rword
);

   logic [WW-1:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (we)
         mem_q[widx] <= wword;
   end

   assign rword = mem_q[ridx];

   always_ff @(posedge clk) begin
      // R9
      if (we)
         word_idx_chk: assert (widx < WAW'(WORDS));
   end

endmodule

// File: rtl/lfifo_reader.sv
module lfifo_reader #(
   parameter int unsigned DW     = 8,
   parameter int unsigned PACK   = 4,
   parameter int unsigned LANE_W = 2
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic               rd_go,
   input  logic [LANE_W-1:0]  lane,
   input  logic [PACK*DW-1:0] rword,
   input  logic               oe_n,
   output logic [DW-1:0]      dout,
   output logic               drive
);

   logic [DW-1:0] pick;
   logic [DW-1:0] data_q;
   logic          drive_q;

   generate
      if (PACK == 1) begin : g_whole
         assign pick = rword;
      end else begin : g_select
         assign pick = rword[lane*DW +: DW];
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         data_q  <= '0;
         drive_q <= 1'b0;
      end else begin
         if (rd_go)
            data_q <= pick;
         drive_q <= !oe_n;
      end
   end

   assign dout  = drive_q ? data_q : '0;
   assign drive = drive_q;

   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !rd_go |=> $stable(data_q));

endmodule

// File: rtl/line_delay_fifo.sv
module line_delay_fifo #(
   parameter int unsigned DEPTH = 5120,
   parameter int unsigned DW    = 8,
   parameter int unsigned PACK  = 4
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          wr_rst_n,
   input  logic          wr_en_n,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_rst_n,
   input  logic          rd_en_n,
   input  logic          out_en_n,
   output logic [DW-1:0] rd_data,
   output logic          rd_drive
);

   localparam int unsigned AW     = $clog2(DEPTH);
   localparam int unsigned LW     = (PACK > 1) ? $clog2(PACK) : 0;
   localparam int unsigned WAW    = AW - LW;
   localparam int unsigned WORDS  = DEPTH / PACK;
   localparam int unsigned WW     = PACK * DW;
   localparam int unsigned LANE_W = (PACK > 1) ? LW : 1;

   generate
      if (PACK == 0 || (PACK & (PACK - 1)) != 0) begin : g_bad_pack
         $error("PACK must be a nonzero power of two");
      end
      if (DEPTH % PACK != 0 || DEPTH <= PACK) begin : g_bad_depth
         $error("DEPTH must be a multiple of PACK and larger than it");
      end
      if (DW == 0) begin : g_bad_width
         $error("DW must be nonzero");
      end
   endgenerate

   logic [AW-1:0]     wr_ptr, wr_addr, rd_ptr, rd_addr;
   logic              wr_go, rd_go;
   logic              commit;
   logic [WAW-1:0]    commit_idx;
   logic [WW-1:0]     commit_word, rword;
   logic [LANE_W-1:0] rd_lane;

   lfifo_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
      .clk(clk), .arst_n(arst_n), .en_n(wr_en_n), .zero_n(wr_rst_n),
      .ptr_q(wr_ptr), .cur_addr(wr_addr), .step(wr_go)
   );

   lfifo_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
      .clk(clk), .arst_n(arst_n), .en_n(rd_en_n), .zero_n(rd_rst_n),
      .ptr_q(rd_ptr), .cur_addr(rd_addr), .step(rd_go)
   );

   lfifo_packer #(.DW(DW), .PACK(PACK), .AW(AW), .LW(LW), .WAW(WAW)) u_pack (
      .clk(clk), .arst_n(arst_n), .wr_go(wr_go), .wr_addr(wr_addr), .din(wr_data),
      .commit(commit), .commit_idx(commit_idx), .commit_word(commit_word)
   );

   lfifo_word_store #(.WW(WW), .WORDS(WORDS), .WAW(WAW)) u_store (
      .clk(clk), .we(commit), .widx(commit_idx), .wword(commit_word),
      .ridx(rd_addr[AW-1:LW]), .rword(rword)
   );

   generate
      if (PACK > 1) begin : g_lane_sel
         assign rd_lane = rd_addr[LW-1:0];
      end else begin : g_lane_none
         assign rd_lane = 1'b0;
      end
   endgenerate

   lfifo_reader #(.DW(DW), .PACK(PACK), .LANE_W(LANE_W)) u_read (
      .clk(clk), .arst_n(arst_n), .rd_go(rd_go), .lane(rd_lane), .rword(rword),
      .oe_n(out_en_n), .dout(rd_data), .drive(rd_drive)
   );

   // R4
   wr_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!wr_rst_n && wr_en_n) |=> (wr_ptr == '0));

   // R4
   wr_restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!wr_rst_n && !wr_en_n) |=> (wr_ptr == AW'(1)));

   // R5
   rd_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!rd_rst_n && rd_en_n) |=> (rd_ptr == '0 && $stable(rd_data)));

   // R6
   oe_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
      out_en_n |=> (!rd_drive && rd_data == '0));

   // R6
   oe_on_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !out_en_n |=> rd_drive);

endmodule

// File: tb/sim_line_delay_fifo.sv
module sim_line_delay_fifo;

   localparam int DEPTH = 5120;

   typedef struct packed {
      int lag;
      int len;
      int tag;
   } scen_t;

   // lag 0 -> R7, lags 20/21/333 -> R8, lags 1..3 -> R9
   localparam scen_t SCEN [7] = '{
      '{0,   48, 7},
      '{21,  48, 8},
      '{20,  48, 8},
      '{333, 48, 8},
      '{1,   24, 9},
      '{2,   24, 9},
      '{3,   24, 9}
   };

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       wr_rst_n = 1'b1, wr_en_n = 1'b1, rd_rst_n = 1'b1, rd_en_n = 1'b1, out_en_n = 1'b1;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       rd_drive;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   int mw = 0, mr = 0, wcnt = 0;
   logic [7:0] cur  [DEPTH];
   logic [7:0] prev [DEPTH];
   logic [7:0] exp_dout = 8'h00;
   bit         exp_drv = 1'b0;

   always #10 clk = ~clk;

   line_delay_fifo u0 (
      .clk(clk), .arst_n(arst_n), .wr_rst_n(wr_rst_n), .wr_en_n(wr_en_n),
      .wr_data(wr_data), .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n),
      .out_en_n(out_en_n), .rd_data(rd_data), .rd_drive(rd_drive)
   );

   function automatic logic [7:0] byte_of(input int k);
      logic [31:0] u;
      u = k;
      return u[7:0] ^ u[15:8] ^ 8'h5A;
   endfunction

   task automatic chk(input int tag, input logic [7:0] got_d, input logic [7:0] want_d,
                      input logic got_v, input logic want_v);
      checks++;
      if (got_d !== want_d || got_v !== want_v) begin
         errors++;
         $display("FAIL R%0d: data=%02h drive=%0b expected data=%02h drive=%0b",
                  tag, got_d, got_v, want_d, want_v);
      end
   endtask

   // One clock cycle; flags are 1 for "active".
   task automatic cyc(input bit wen, input bit ren, input bit wrst, input bit rrst,
                      input bit oen, input bit do_chk, input int tag);
      int weff, reff, gw;
      logic [7:0] d;
      @(negedge clk);
      wr_en_n  = !wen;
      rd_en_n  = !ren;
      wr_rst_n = !wrst;
      rd_rst_n = !rrst;
      out_en_n = oen;
      d        = byte_of(wcnt);
      wr_data  = d;
      weff = wrst ? 0 : mw;
      reff = rrst ? 0 : mr;
      gw   = wen ? weff : mw;
      if (ren) begin
         // R9: word of 4 committed only when its top lane is written
         if ((reff / 4 == gw / 4) && (reff % 4 < gw % 4))
            exp_dout = prev[reff];
         else
            exp_dout = cur[reff];
         mr = (reff == DEPTH - 1) ? 0 : reff + 1;
      end else if (rrst) begin
         mr = 0;
      end
      if (wen) begin
         prev[weff] = cur[weff];
         cur[weff]  = d;
         mw = (weff == DEPTH - 1) ? 0 : weff + 1;
         wcnt++;
      end else if (wrst) begin
         mw = 0;
      end
      exp_drv = !oen;
      @(posedge clk);
      #5;
      if (do_chk)
         chk(tag, rd_data, exp_drv ? exp_dout : 8'h00, rd_drive, exp_drv);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         cur[i]  = 8'h00;
         prev[i] = 8'h00;
      end
      repeat (3) @(posedge clk);
      #5;
      // R1: outputs quiet during reset
      chk(1, rd_data, 8'h00, rd_drive, 1'b0);
      @(negedge clk);
      arst_n = 1'b1;

      // two fill passes, unchecked
      repeat (2 * DEPTH) cyc(1, 1, 0, 0, 0, 0, 0);

      // vector table: read lag sweep
      for (int s = 0; s < 7; s++) begin
         while (mw != SCEN[s].lag) cyc(1, 1, 0, 0, 0, 0, 0);
         cyc(1, 1, 0, 1, 0, 1, SCEN[s].tag);
         for (int k = 0; k < SCEN[s].len; k++) cyc(1, 1, 0, 0, 0, 1, SCEN[s].tag);
      end

      // R3: read stall holds output, then delay grows
      repeat (4) cyc(1, 0, 0, 0, 0, 1, 3);
      repeat (8) cyc(1, 1, 0, 0, 0, 1, 3);

      // R2: write stall stores nothing and holds the pointer
      repeat (3) cyc(0, 1, 0, 0, 0, 1, 2);
      repeat (30) cyc(1, 1, 0, 0, 0, 1, 2);

      // R6: output disabled, read pointer keeps moving
      repeat (5) cyc(1, 1, 0, 0, 1, 1, 6);
      repeat (10) cyc(1, 1, 0, 0, 0, 1, 6);

      // R5: read restart without read keeps output, next read from 0
      cyc(1, 0, 0, 1, 0, 1, 5);
      repeat (12) cyc(1, 1, 0, 0, 0, 1, 5);

      // R4: write restart together with a write
      while (mw % 4 != 0) cyc(1, 1, 0, 0, 0, 0, 0);
      cyc(1, 1, 1, 0, 0, 0, 0);
      repeat (29) cyc(1, 1, 0, 0, 0, 0, 0);
      cyc(1, 1, 0, 1, 0, 1, 4);
      repeat (25) cyc(1, 1, 0, 0, 0, 1, 4);

      // R4: write restart with the write disabled
      while (mw % 4 != 0) cyc(1, 1, 0, 0, 0, 0, 0);
      cyc(0, 1, 1, 0, 0, 0, 0);
      repeat (29) cyc(1, 1, 0, 0, 0, 0, 0);
      cyc(1, 1, 0, 1, 0, 1, 4);
      repeat (25) cyc(1, 1, 0, 0, 0, 1, 4);

      // R1: mid-run system reset at a word boundary
      while (mw % 4 != 0) cyc(1, 1, 0, 0, 0, 0, 0);
      @(negedge clk);
      arst_n = 1'b0;
      #2;
      chk(1, rd_data, 8'h00, rd_drive, 1'b0);
      mw = 0;
      mr = 0;
      exp_dout = 8'h00;
      exp_drv = 1'b0;
      @(posedge clk);
      #5;
      chk(1, rd_data, 8'h00, rd_drive, 1'b0);
      arst_n = 1'b1;
      repeat (20) cyc(1, 1, 0, 0, 0, 1, 1);

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule